// File: doc/BRIEF.md
# Descriptor-Chain Memory-to-Stream Engine

This block is the outbound half of a DMA channel. It follows a linked list of four-word data descriptors held in memory, reads the buffer each one names and sends it word by word on a valid/ready stream, and marks the end of a packet where a descriptor asks for it. When a descriptor's buffer has been sent, the engine writes the descriptor back to its own address. It then either moves to the next descriptor through the next pointer, or records end-of-list and goes quiet. A single-word request/acknowledge port with one access in flight carries all memory traffic.

Software, through a register block that is not part of this design, starts the engine at a descriptor address. After the list ends, software can patch the tail descriptor, clearing its end-of-list bit and pointing it at new work, and then issue a continue. The engine re-reads that descriptor and resumes when the bit is now clear. Per-descriptor completion interrupts and end-of-list status go back to the register block. A sideband output carries each packet's 16-bit metadata ahead of its data.

A descriptor at byte address A holds four words:

| Address | Contents |
|---|---|
| A+0 | next pointer |
| A+4 | buffer start |
| A+8 | flags |
| A+12 | end address (the first byte after the data) |

The flags word has these fields:

| Bits | Meaning |
|---|---|
| 0 | end-of-list |
| 3 | out end-of-packet |
| 4 | interrupt on completion |
| 31:16 | metadata |

The remaining flag bits are carried through and written back unchanged. The remaining length is the end address minus the current buffer pointer. The engine reads it in bursts of at most `MAX_BURST_BYTES`.

The controller has these states: IDLE, FETCH, META, PLAN, READ, PUSH, WBACK and DONE. Its transitions are:

- IDLE→FETCH on an accepted start or an accepted continue.
- FETCH→META after the fourth descriptor word when metadata is owed.
- FETCH→PLAN after the fourth descriptor word when no metadata is owed.
- On a continue re-read, FETCH→IDLE when end-of-list is still set.
- On a continue re-read, FETCH→FETCH to the next pointer when end-of-list is now clear.
- META→PLAN.
- PLAN→WBACK when the pointer has reached the end address.
- PLAN→READ to begin a burst.
- READ→PUSH on the read acknowledge.
- PUSH→READ on ready while the burst has words left.
- PUSH→PLAN on ready for the last word of a burst.
- WBACK→DONE after the fourth write acknowledge.
- DONE→IDLE on end-of-list.
- DONE→FETCH to the next pointer otherwise.

Top module: `dscr_out_engine`

## Requirements
- R1: After reset there is no memory request, no stream or metadata beat and no interrupt pulse, and the busy, running and end-of-list outputs are low.
- R2: In IDLE, a start is accepted only while `cfg_enable` is 1 and `cfg_stop` is 0. An accepted start clears the end-of-list flag, sets running, and reads the four descriptor words at `start_addr` +0, +4, +8 and +12.
- R3: Buffer words are streamed in ascending address order, from buffer start up to but excluding the end address. Addresses and lengths are multiples of 4. A descriptor whose end address is not above its buffer start sends no data word.
- R4: Reads are split into bursts of at most `MAX_BURST_BYTES`. `strm_last` is 1 only on the final word of a descriptor whose flags bit 3 is set, even when its buffer spans several bursts.
- R5: `meta_valid` pulses for one cycle with flags bits 31:16 before the first data word of three kinds of descriptor: the first one after a start, the first one after a continue restart, and one that follows a completed descriptor with bit 3 set. It is never high together with `strm_valid`.
- R6: Every completed descriptor is written back as four words to its own address before the next descriptor is fetched.
- R7: `irq_done` pulses for one cycle for each completed descriptor whose flags bit 4 is set.
- R8: When a completed descriptor has flags bit 0 set, `eol_flag` goes to 1 and the engine returns to IDLE. It sends no further stream beat while the flag is 1.
- R9: A continue is honoured only in IDLE, while enabled, not stopped, running, with `eol_flag` 1 and the cached descriptor's bit 0 set. The engine re-reads all four words. If bit 0 is still set, it returns to IDLE with `eol_flag` still 1. Otherwise it clears `eol_flag` and restarts at the next pointer, presenting metadata first.
- R10: `cfg_stop` at 1 or `cfg_enable` at 0 clears running by the next cycle. While stopped or disabled, start and continue cause no memory traffic. After the stop is released, a continue stays ignored until a new start.
- R11: `mem_req` and its address, direction and write data hold until `mem_ack`. `strm_valid`, data and last hold until `strm_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_stop | input | 1 | Channel stop request |
| start | input | 1 | Start pulse |
| start_addr | input | 32 | First descriptor byte address |
| cont | input | 1 | Continue pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| strm_valid | output | 1 | Stream word valid |
| strm_ready | input | 1 | Stream sink ready |
| strm_data | output | 32 | Stream word |
| strm_last | output | 1 | End of packet on this word |
| meta_valid | output | 1 | Metadata pulse |
| meta_data | output | 16 | Packet metadata |
| irq_done | output | 1 | Descriptor-complete interrupt pulse |
| eol_flag | output | 1 | End-of-list recorded |
| running | output | 1 | Channel in running mode |
| busy | output | 1 | Controller not in IDLE |

## Verification
Each stream word appears in the cycle after the acknowledge of its read. The metadata pulse comes one cycle after the acknowledge of the fourth descriptor word. The interrupt pulse falls in the cycle after the fourth write-back acknowledge. `eol_flag` rises together with the return to IDLE. The memory model and the stream sink answer after random delays, so the bench does not rely on fixed cycle stamps. At every falling edge it records each completed handshake and each pulse, tagging each metadata pulse with the number of data words seen before it. After `busy` falls it compares these logs, whole, against sequences computed by walking the descriptor list in its own memory image. The ignore and gate cases are checked by counting memory transactions over a fixed window after the stimulus.

// File: rtl/dso_pkg.sv
package dso_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;
    localparam int META_W = 16;

    // flags word field positions (decoded by software and by this engine)
    localparam int FLG_EOL  = 0;
    localparam int FLG_OEOP = 3;
    localparam int FLG_INTR = 4;
    localparam int FLG_META = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_META,
        ST_PLAN,
        ST_READ,
        ST_PUSH,
        ST_WBACK,
        ST_DONE
    } dso_state_e;

endpackage

// File: rtl/dso_len_calc.sv
module dso_len_calc
    import dso_pkg::*;
#(
    parameter int MAX_BURST_BYTES = 2048,
    parameter int BURST_W         = $clog2(MAX_BURST_BYTES) + 1
) (
    input  logic [ADDR_W-1:0]  cur_ptr,
    input  logic [ADDR_W-1:0]  end_addr,
    output logic [BURST_W-1:0] burst_bytes,
    output logic               at_end,
    output logic               final_burst
);

    logic [ADDR_W-1:0] remain;

    always_comb begin
        remain      = end_addr - cur_ptr;
        at_end      = (end_addr <= cur_ptr);
        final_burst = (remain <= ADDR_W'(MAX_BURST_BYTES));
        burst_bytes = final_burst ? remain[BURST_W-1:0] : BURST_W'(MAX_BURST_BYTES);
    end

endmodule

// File: rtl/dso_seq.sv
module dso_seq
    import dso_pkg::*;
#(
    parameter int BURST_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_stop,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               cont,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               strm_valid,
    input  logic               strm_ready,
    output logic [WORD_W-1:0]  strm_data,
    output logic               strm_last,
    output logic               meta_valid,
    output logic [META_W-1:0]  meta_data,
    output logic               irq_done,
    output logic               eol_flag,
    output logic               running,
    output logic               busy,
    output logic [ADDR_W-1:0]  calc_ptr,
    output logic [ADDR_W-1:0]  calc_end,
    input  logic [BURST_W-1:0] calc_burst,
    input  logic               calc_at_end,
    input  logic               calc_final
);

    localparam logic [BURST_W-1:0] WORD_BYTES = BURST_W'(4);

    dso_state_e        state, state_nx;
    logic [1:0]        word_idx;
    logic              cont_mode;
    logic              meta_owed;
    logic [ADDR_W-1:0] dscr_addr;
    logic [ADDR_W-1:0] d_next;
    logic [ADDR_W-1:0] d_buf;
    logic [WORD_W-1:0] d_flags;
    logic [ADDR_W-1:0] d_end;
    logic [ADDR_W-1:0] ptr;
    logic [BURST_W-1:0] burst_left;
    logic              burst_final;
    logic [WORD_W-1:0] data_q;

    logic start_ok;
    logic cont_ok;
    logic gate_open;

    assign gate_open = cfg_enable && !cfg_stop;
    assign start_ok  = (state == ST_IDLE) && start && gate_open;
    assign cont_ok   = (state == ST_IDLE) && cont && gate_open && running
                       && eol_flag && d_flags[FLG_EOL];

    assign calc_ptr = ptr;
    assign calc_end = d_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ok || cont_ok) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_ack && word_idx == 2'd3) begin
                    if (cont_mode)      state_nx = d_flags[FLG_EOL] ? ST_IDLE : ST_FETCH;
                    else if (meta_owed) state_nx = ST_META;
                    else                state_nx = ST_PLAN;
                end
            end
            ST_META:  state_nx = ST_PLAN;
            ST_PLAN:  state_nx = calc_at_end ? ST_WBACK : ST_READ;
            ST_READ: begin
                if (mem_ack) state_nx = ST_PUSH;
            end
            ST_PUSH: begin
                if (strm_ready) state_nx = (burst_left <= WORD_BYTES) ? ST_PLAN : ST_READ;
            end
            ST_WBACK: begin
                if (mem_ack && word_idx == 2'd3) state_nx = ST_DONE;
            end
            ST_DONE:  state_nx = d_flags[FLG_EOL] ? ST_IDLE : ST_FETCH;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx    <= '0;
            cont_mode   <= 1'b0;
            meta_owed   <= 1'b0;
            dscr_addr   <= '0;
            d_next      <= '0;
            d_buf       <= '0;
            d_flags     <= '0;
            d_end       <= '0;
            ptr         <= '0;
            burst_left  <= '0;
            burst_final <= 1'b0;
            data_q      <= '0;
            eol_flag    <= 1'b0;
            running     <= 1'b0;
        end else begin
            if (!gate_open) running <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        dscr_addr <= start_addr;
                        eol_flag  <= 1'b0;
                        running   <= 1'b1;
                        cont_mode <= 1'b0;
                        meta_owed <= 1'b1;
                        word_idx  <= '0;
                    end else if (cont_ok) begin
                        cont_mode <= 1'b1;
                        word_idx  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        word_idx <= word_idx + 2'd1;
                        unique case (word_idx)
                            2'd0: d_next  <= mem_rdata;
                            2'd1: d_buf   <= mem_rdata;
                            2'd2: d_flags <= mem_rdata;
                            2'd3: d_end   <= mem_rdata;
                            default: ;
                        endcase
                        if (word_idx == 2'd3) begin
                            if (cont_mode) begin
                                cont_mode <= 1'b0;
                                if (!d_flags[FLG_EOL]) begin
                                    dscr_addr <= d_next;
                                    eol_flag  <= 1'b0;
                                    meta_owed <= 1'b1;
                                end
                            end else begin
                                ptr <= d_buf;
                            end
                        end
                    end
                end
                ST_META: meta_owed <= 1'b0;
                ST_PLAN: begin
                    burst_left  <= calc_burst;
                    burst_final <= calc_final;
                    word_idx    <= '0;
                end
                ST_READ: begin
                    if (mem_ack) data_q <= mem_rdata;
                end
                ST_PUSH: begin
                    if (strm_ready) begin
                        ptr        <= ptr + ADDR_W'(4);
                        burst_left <= burst_left - WORD_BYTES;
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) word_idx <= word_idx + 2'd1;
                end
                ST_DONE: begin
                    word_idx <= '0;
                    if (d_flags[FLG_EOL]) begin
                        eol_flag <= 1'b1;
                    end else begin
                        dscr_addr <= d_next;
                        meta_owed <= d_flags[FLG_OEOP];
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = dscr_addr + {{(ADDR_W-4){1'b0}}, word_idx, 2'b00};
        unique case (word_idx)
            2'd0: mem_wdata = d_next;
            2'd1: mem_wdata = d_buf;
            2'd2: mem_wdata = d_flags;
            2'd3: mem_wdata = d_end;
            default: mem_wdata = d_next;
        endcase
        strm_valid = 1'b0;
        strm_last  = 1'b0;
        strm_data  = data_q;
        meta_valid = 1'b0;
        meta_data  = d_flags[FLG_META +: META_W];
        irq_done   = 1'b0;
        busy       = (state != ST_IDLE);
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_META:  meta_valid = 1'b1;
            ST_PUSH: begin
                strm_valid = 1'b1;
                strm_last  = burst_final && (burst_left <= WORD_BYTES) && d_flags[FLG_OEOP];
            end
            ST_DONE:  irq_done = d_flags[FLG_INTR];
            default: ;
        endcase
    end

endmodule

// File: rtl/dscr_out_engine.sv
module dscr_out_engine
    import dso_pkg::*;
#(
    parameter int MAX_BURST_BYTES = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_stop,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                cont,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                strm_valid,
    input  logic                strm_ready,
    output logic [WORD_W-1:0]   strm_data,
    output logic                strm_last,
    output logic                meta_valid,
    output logic [META_W-1:0]   meta_data,
    output logic                irq_done,
    output logic                eol_flag,
    output logic                running,
    output logic                busy
);

    localparam int BURST_W = $clog2(MAX_BURST_BYTES) + 1;

    logic [ADDR_W-1:0]  calc_ptr;
    logic [ADDR_W-1:0]  calc_end;
    logic [BURST_W-1:0] calc_burst;
    logic               calc_at_end;
    logic               calc_final;

    dso_len_calc #(
        .MAX_BURST_BYTES (MAX_BURST_BYTES),
        .BURST_W         (BURST_W)
    ) i_len (
        .cur_ptr     (calc_ptr),
        .end_addr    (calc_end),
        .burst_bytes (calc_burst),
        .at_end      (calc_at_end),
        .final_burst (calc_final)
    );

    dso_seq #(
        .BURST_W (BURST_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_enable  (cfg_enable),
        .cfg_stop    (cfg_stop),
        .start       (start),
        .start_addr  (start_addr),
        .cont        (cont),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .strm_valid  (strm_valid),
        .strm_ready  (strm_ready),
        .strm_data   (strm_data),
        .strm_last   (strm_last),
        .meta_valid  (meta_valid),
        .meta_data   (meta_data),
        .irq_done    (irq_done),
        .eol_flag    (eol_flag),
        .running     (running),
        .busy        (busy),
        .calc_ptr    (calc_ptr),
        .calc_end    (calc_end),
        .calc_burst  (calc_burst),
        .calc_at_end (calc_at_end),
        .calc_final  (calc_final)
    );

endmodule

// File: rtl/dscr_out_engine_chk.sv
module dscr_out_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_enable,
    input logic        cfg_stop,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        strm_valid,
    input logic        strm_ready,
    input logic [31:0] strm_data,
    input logic        strm_last,
    input logic        meta_valid,
    input logic        irq_done,
    input logic        eol_flag,
    input logic        running
);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    AST_STRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        strm_valid && !strm_ready |=> strm_valid && $stable(strm_data) && $stable(strm_last)); // R11

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R3

    AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        strm_last |-> strm_valid); // R4

    AST_META_APART: assert property (@(posedge clk) disable iff (!rst_n)
        meta_valid |-> !strm_valid); // R5

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R7

    AST_EOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        eol_flag |-> !strm_valid && !meta_valid); // R8

    AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stop || !cfg_enable) |=> !running); // R10

endmodule

bind dscr_out_engine dscr_out_engine_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_stop   (cfg_stop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .strm_valid (strm_valid),
    .strm_ready (strm_ready),
    .strm_data  (strm_data),
    .strm_last  (strm_last),
    .meta_valid (meta_valid),
    .irq_done   (irq_done),
    .eol_flag   (eol_flag),
    .running    (running)
);

// File: tb/test_dscr_out_engine.sv
module test_dscr_out_engine;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_stop = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        cont = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        strm_valid, strm_last;
    logic        strm_ready = 1'b0;
    logic [31:0] strm_data;
    logic        meta_valid;
    logic [15:0] meta_data;
    logic        irq_done, eol_flag, running, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    dscr_out_engine i_dscr_out_engine (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_stop(cfg_stop),
        .start(start), .start_addr(start_addr), .cont(cont),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .strm_valid(strm_valid), .strm_ready(strm_ready), .strm_data(strm_data),
        .strm_last(strm_last), .meta_valid(meta_valid), .meta_data(meta_data),
        .irq_done(irq_done), .eol_flag(eol_flag), .running(running), .busy(busy)
    );

    logic [31:0] mem [0:MEM_WORDS-1];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // captured activity
    int unsigned got_w[$];
    bit          got_l[$];
    int          got_mpos[$];
    int unsigned got_mval[$];
    int got_irq = 0, wr_cnt = 0, wb_bad = 0, txn = 0, wait_cnt = 0;

    // expected activity
    int unsigned exp_w[$];
    bit          exp_l[$];
    int          exp_mpos[$];
    int unsigned exp_mval[$];
    int exp_irq = 0, exp_nd = 0;

    // list building
    int unsigned dp = 32'h100, bp = 32'h4000, prev_d = 0;
    bit have_prev = 0;

    // memory model, stream sink and monitors, all on the falling edge
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n) begin
            if (mem_req) begin
                if (wait_cnt == 0) begin
                    txn++;
                    if (mem_we) begin
                        if (mem[(mem_addr >> 2) % MEM_WORDS] != mem_wdata) wb_bad++;
                        mem[(mem_addr >> 2) % MEM_WORDS] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata <= mem[(mem_addr >> 2) % MEM_WORDS];
                    end
                    mem_ack  <= 1'b1;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
            strm_ready = ($urandom % 4) != 0;
            if (strm_valid && strm_ready) begin
                got_w.push_back(strm_data);
                got_l.push_back(strm_last);
            end
            if (meta_valid) begin
                got_mpos.push_back(got_w.size());
                got_mval.push_back(meta_data);
            end
            if (irq_done) got_irq++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_desc(input int nw, input bit eop, input bit intr, input bit eol,
                            output int unsigned at);
        if (bp + nw * 4 > 32'h8000) bp = 32'h4000;
        if (dp > 32'h3F00) dp = 32'h100;
        at = dp;
        dp += 16;
        mem[at >> 2]       = 32'h0;
        mem[(at >> 2) + 1] = bp;
        mem[(at >> 2) + 2] = {16'($urandom), 11'b0, intr, eop, 2'b00, eol};
        mem[(at >> 2) + 3] = bp + nw * 4;
        for (int i = 0; i < nw; i++) mem[(bp >> 2) + i] = $urandom;
        bp += nw * 4;
        if (have_prev) mem[prev_d >> 2] = at;
        prev_d = at;
        have_prev = 1;
    endtask

    // independent walk of the list from the requirements (R3..R8)
    task automatic model_walk(input int unsigned head);
        int unsigned a;
        bit pend;
        a = head;
        pend = 1;
        for (int k = 0; k < 64; k++) begin
            int unsigned nx, b, f, e;
            nx = mem[a >> 2];
            b  = mem[(a >> 2) + 1];
            f  = mem[(a >> 2) + 2];
            e  = mem[(a >> 2) + 3];
            if (pend) begin
                exp_mpos.push_back(exp_w.size());
                exp_mval.push_back(f >> 16);
            end
            for (int unsigned p = b; p < e; p += 4) begin
                exp_w.push_back(mem[p >> 2]);
                exp_l.push_back((p + 4 == e) && f[3]);
            end
            if (f[4]) exp_irq++;
            exp_nd++;
            if (f[0]) break;
            pend = f[3];
            a = nx;
        end
    endtask

    task automatic clear_logs();
        got_w.delete(); got_l.delete(); got_mpos.delete(); got_mval.delete();
        exp_w.delete(); exp_l.delete(); exp_mpos.delete(); exp_mval.delete();
        got_irq = 0; wr_cnt = 0; wb_bad = 0; exp_irq = 0; exp_nd = 0;
    endtask

    task automatic pulse_start(input int unsigned head);
        @(negedge clk);
        start_addr = head;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_cont();
        @(negedge clk);
        cont = 1'b1;
        @(negedge clk);
        cont = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 40000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(!busy, "R8", "engine returned to idle", busy, 0);
    endtask

    task automatic compare(input string tag);
        int bad_w, bad_l, bad_m;
        bad_w = 0; bad_l = 0; bad_m = 0;
        chk(got_w.size() == exp_w.size(), "R3", {tag, " word count"}, got_w.size(), exp_w.size());
        if (got_w.size() == exp_w.size()) begin
            foreach (exp_w[i]) begin
                if (got_w[i] != exp_w[i]) bad_w++;
                if (got_l[i] != exp_l[i]) bad_l++;
            end
        end
        chk(bad_w == 0, "R3", {tag, " word mismatches"}, bad_w, 0);
        chk(bad_l == 0, "R4", {tag, " last-marker mismatches"}, bad_l, 0);
        chk(got_mval.size() == exp_mval.size(), "R5", {tag, " metadata count"},
            got_mval.size(), exp_mval.size());
        if (got_mval.size() == exp_mval.size()) begin
            foreach (exp_mval[i])
                if (got_mval[i] != exp_mval[i] || got_mpos[i] != exp_mpos[i]) bad_m++;
        end
        chk(bad_m == 0, "R5", {tag, " metadata value/position mismatches"}, bad_m, 0);
        chk(got_irq == exp_irq, "R7", {tag, " interrupt pulses"}, got_irq, exp_irq);
        chk(wr_cnt == 4 * exp_nd, "R6", {tag, " write-back words"}, wr_cnt, 4 * exp_nd);
        chk(wb_bad == 0, "R6", {tag, " write-back content"}, wb_bad, 0);
        chk(eol_flag == 1'b1, "R8", {tag, " end-of-list flag"}, eol_flag, 1);
    endtask

    task automatic run_list(input string tag, input int unsigned head, input bit by_cont);
        clear_logs();
        model_walk(head);
        if (by_cont) pulse_cont();
        else         pulse_start(head);
        wait_idle();
        compare(tag);
    endtask

    initial begin
        int unsigned h, t, tail, t0;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req && !strm_valid && !meta_valid && !irq_done, "R1", "quiet outputs",
            {mem_req, strm_valid, meta_valid, irq_done}, 0);
        chk(!busy && !running && !eol_flag, "R1", "status low", {busy, running, eol_flag}, 0);

        // R2 start ignored while disabled
        have_prev = 0;
        add_desc(2, 1, 0, 1, h);
        t0 = txn;
        pulse_start(h);
        repeat (10) @(negedge clk);
        chk(txn == t0, "R2", "start while disabled causes no traffic", txn - t0, 0);
        chk(!running, "R2", "running stays low", running, 0);
        cfg_enable = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R7 directed: zero-length middle descriptor
        have_prev = 0;
        add_desc(3, 1, 0, 0, h);
        add_desc(0, 1, 1, 0, t);
        add_desc(5, 1, 1, 1, t);
        run_list("directed", h, 0);
        chk(running, "R2", "running after start", running, 1);

        // R4 buffer spanning several bursts, end-of-packet on final word only
        have_prev = 0;
        add_desc(514, 1, 1, 1, h);
        run_list("long", h, 0);

        // random lists
        for (int s = 0; s < 6; s++) begin
            have_prev = 0;
            n = 1 + $urandom % 4;
            for (int d = 0; d < n; d++) begin
                add_desc($urandom % 24, 1'($urandom), 1'($urandom), d == n - 1, t);
                if (d == 0) h = t;
            end
            run_list($sformatf("random%0d", s), h, 0);
        end
        tail = prev_d;

        // R9 continue with end-of-list still set: re-read only
        clear_logs();
        t0 = txn;
        pulse_cont();
        wait_idle();
        chk(txn - t0 == 4, "R9", "re-read transactions", txn - t0, 4);
        chk(got_w.size() == 0, "R9", "no data after re-read", got_w.size(), 0);
        chk(eol_flag, "R9", "end-of-list kept", eol_flag, 1);

        // R9 continue after patching the tail
        have_prev = 0;
        add_desc(4, 1, 1, 0, h);
        add_desc(6, 0, 0, 1, t);
        mem[tail >> 2] = h;
        mem[(tail >> 2) + 2] = mem[(tail >> 2) + 2] & ~32'h1;
        run_list("continue", h, 1);

        // R10 stop clears running and gates start/continue
        cfg_stop = 1'b1;
        repeat (2) @(negedge clk);
        chk(!running, "R10", "running cleared by stop", running, 0);
        t0 = txn;
        pulse_cont();
        pulse_start(h);
        repeat (10) @(negedge clk);
        chk(txn == t0, "R10", "no traffic while stopped", txn - t0, 0);
        cfg_stop = 1'b0;
        pulse_cont();
        repeat (10) @(negedge clk);
        chk(txn == t0, "R10", "continue ignored after stop release", txn - t0, 0);
        have_prev = 0;
        add_desc(3, 1, 0, 1, h);
        run_list("restart", h, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule